// File: doc/BRIEF.md
# Serial PHY Management Master

This block is the master side of a two-wire serial management link, used to read and write 16-bit registers inside an attached PHY. A client presents one request at a time: a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs a complete frame on the link and pulses `done`. For a read, `done` comes with the register value and an error flag.

The management clock `mdc` is produced by dividing the system clock. Each half-period lasts `HALF_DIV` system clocks, so the default of 25 at a 125 MHz system clock gives a 400 ns link period. The bidirectional data pad lives outside the block as three signals: a driven level, an output enable and a sampled input. A separate direction indication follows the enable and is meant for an external level shifter.

Every frame has 64 clock pulses. The first 32 carry an all-ones preamble. Next come the start code, the opcode and the two addresses. For a write, the master continues with a fixed turnaround pattern and then the data. For a read, the master hands the line to the PHY, checks the PHY's turnaround bit and shifts in 16 data bits. The line is handed over and taken back only while the clock sits low.

Top module: `mgmt_serial_master`

## Requirements
- R1: Out of reset and whenever idle, `busy`=0, `done`=0, `mdc`=0, `mdio_oe`=1, `mdio_dir`=1 and `mdio_o`=1.
- R2: A request is taken when `req_valid` is high while `busy` is low. `busy` is high from the next cycle up to and including the `done` cycle. Requests presented while `busy` is high are ignored and produce no frame and no `done`.
- R3: `mdc` stays high for exactly `HALF_DIV` system clocks per pulse. In the preamble, successive rising edges are 2·`HALF_DIV` clocks apart. `mdio_o` and `mdio_oe` never change in a cycle where `mdc` is high.
- R4: The first 32 rising edges of every frame see `mdio_o`=1 with `mdio_oe`=1.
- R5: Rising edges 33 to 46 carry the start code 01, then the opcode (read 10, write 01), then the PHY address and then the register address, each MSB first.
- R6: In a write, rising edges 47 and 48 carry the pattern 10, and edges 49 to 64 carry the write data MSB first. `mdio_oe` stays 1 for the whole frame, which has 64 rising edges.
- R7: In a read, `mdio_oe` and `mdio_dir` fall after rising edge 46 and are low at edges 47 to 64. They return to 1 before `done`. `mdio_dir` always equals `mdio_oe`, and either one changes only when `mdc` was low in both the previous cycle and the current one.
- R8: In a read, `mdio_i` is sampled in the last system clock before rising edge 48 as the error indicator. `mdio_i` is sampled before rising edges 49 to 64 as data bits 15 down to 0. The frame has 64 rising edges.
- R9: If the error indicator sampled 1, `rd_err`=1 and `rd_data`=0 whatever the data bits were. Otherwise `rd_err`=0 and `rd_data` holds the received value.
- R10: `done` is a one-cycle pulse. `rd_data` and `rd_err` are valid in that cycle and stay valid until the next request is taken. After a write, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_regad | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result (0 on error or write) |
| rd_err | output | 1 | PHY did not drive its turnaround bit low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data level driven onto the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_dir | output | 1 | Direction indication, 1 = host to PHY |
| mdio_i | input | 1 | Data level sampled from the pad |

## Verification
The bench sweeps all 32 register addresses with a write and then a read-back against a PHY model. It compares every captured frame bit and every enable level with a frame that the bench assembles arithmetically, so a swapped field, a wrong opcode or an LSB-first shift would show up as a mismatched bit. Two error cases are covered: an absent PHY, and a PHY that answers with a high turnaround bit while still driving nonzero data. A master that leaked the received bits through in the second case would return nonzero data. A request is also injected in the middle of a frame, and a design that queued or accepted it would produce a second `done` or corrupt the frame in flight. Finally, the bench checks that the pad enable never toggles around a clock edge, since a master that released the line together with the clock fall would collide with the PHY's turnaround.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int SLOT_W     = $clog2(FRAME_BITS);

    // first slot after the header; reads hand the line over here
    localparam int HDR_END    = PRE_BITS + 4 + 2 * ADDR_W;
    // slot whose rising edge is preceded by the turnaround sample
    localparam int ERR_SLOT   = HDR_END + 1;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] WR_TURN  = 2'b10;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_LOW,
        MS_HIGH,
        MS_TURN,
        MS_TAIL,
        MS_FIN
    } ms_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mgmt_req_t;

    function automatic logic [FRAME_BITS-1:0] frame_bits(input mgmt_req_t r);
        frame_bits = {{PRE_BITS{1'b1}}, SOF_CODE, (r.wr ? OP_WRITE : OP_READ),
                      r.phy, r.regad, WR_TURN, r.wdata};
    endfunction

endpackage

// File: rtl/mgmt_half_timer.sv
module mgmt_half_timer #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/mgmt_rx_capture.sv
module mgmt_rx_capture
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take_err,
    input  logic              take_bit,
    input  logic              din,
    output logic              err_flag,
    output logic [DATA_W-1:0] shift_q
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err_flag <= 1'b0;
            shift_q  <= '0;
        end else if (take_err) begin
            err_flag <= din;
        end else if (take_bit) begin
            shift_q  <= {shift_q[DATA_W-2:0], din};
        end
    end

endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
    import mgmt_pkg::*;
#(
    parameter int HALF_DIV = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_regad,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        mdio_dir,
    input  logic        mdio_i
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);
    localparam logic [SLOT_W-1:0] PRE_TURN  = SLOT_W'(HDR_END - 1);
    localparam logic [SLOT_W-1:0] REL_SLOT  = SLOT_W'(HDR_END);
    localparam logic [SLOT_W-1:0] SMP_SLOT  = SLOT_W'(ERR_SLOT);

    ms_state_e             state;
    logic [SLOT_W-1:0]     slot;
    logic [FRAME_BITS-1:0] sh;
    logic                  rd_q;
    mgmt_req_t             req_s;
    logic                  tick;
    logic                  timer_run;
    logic                  accept;
    logic                  released;
    logic                  low_end;
    logic                  rx_err;
    logic [DATA_W-1:0]     rx_bits;

    assign req_s.wr    = req_write;
    assign req_s.phy   = req_phy;
    assign req_s.regad = req_regad;
    assign req_s.wdata = req_wdata;

    assign accept    = (state == MS_IDLE) && req_valid;
    assign timer_run = (state == MS_LOW) || (state == MS_HIGH) || (state == MS_TAIL);
    assign low_end   = (state == MS_LOW) && tick;

    mgmt_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (timer_run),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_IDLE;
            slot  <= '0;
            sh    <= '1;
            rd_q  <= 1'b0;
        end else begin
            case (state)
                MS_IDLE: begin
                    if (accept) begin
                        sh    <= frame_bits(req_s);
                        rd_q  <= !req_write;
                        slot  <= '0;
                        state <= MS_LOW;
                    end
                end
                MS_LOW: begin
                    if (tick) state <= MS_HIGH;
                end
                MS_HIGH: begin
                    if (tick) begin
                        sh <= {sh[FRAME_BITS-2:0], 1'b1};
                        if (slot == LAST_SLOT) begin
                            state <= MS_TAIL;
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= (slot == PRE_TURN) ? MS_TURN : MS_LOW;
                        end
                    end
                end
                MS_TURN: state <= MS_LOW;
                MS_TAIL: begin
                    if (tick) state <= MS_FIN;
                end
                MS_FIN:  state <= MS_IDLE;
                default: state <= MS_IDLE;
            endcase
        end
    end

    // the line belongs to the PHY from the low half after the header
    // until the closing low half of a read
    assign released = rd_q && (slot >= REL_SLOT) &&
                      ((state == MS_LOW) || (state == MS_HIGH) || (state == MS_TAIL));

    mgmt_rx_capture u_rx (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .take_err (rd_q && low_end && (slot == SMP_SLOT)),
        .take_bit (rd_q && low_end && (slot > SMP_SLOT)),
        .din      (mdio_i),
        .err_flag (rx_err),
        .shift_q  (rx_bits)
    );

    assign busy     = (state != MS_IDLE);
    assign done     = (state == MS_FIN);
    assign mdc      = (state == MS_HIGH);
    assign mdio_oe  = !released;
    assign mdio_dir = !released;
    assign mdio_o   = sh[FRAME_BITS-1] & ~released;
    assign rd_err   = rx_err;
    assign rd_data  = rx_err ? '0 : rx_bits;

endmodule

module mgmt_serial_master_chk #(
    parameter int HALF_DIV = 25
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        mdio_dir,
    input logic        rd_err,
    input logic [15:0] rd_data,
    input logic        rd_q
);

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)      hi_run <= '0;
        else if (mdc) hi_run <= hi_run + 1'b1;
        else          hi_run <= '0;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && mdio_oe && mdio_dir && !done));

    p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    p_high_len_r3: assert property (@(posedge clk) disable iff (rst)
        (!mdc && hi_run != 16'd0) |-> (hi_run == 16'(HALF_DIV)));

    p_data_steady_r3: assert property (@(posedge clk) disable iff (rst)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_write_drives_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_q) |-> mdio_oe);

    p_dir_follow_r7: assert property (@(posedge clk) disable iff (rst)
        mdio_dir == mdio_oe);

    p_turn_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe != $past(mdio_oe)) |-> (!mdc && !$past(mdc)));

    p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_data == 16'd0));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

bind mgmt_serial_master mgmt_serial_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .mdio_dir (mdio_dir),
    .rd_err   (rd_err),
    .rd_data  (rd_data),
    .rd_q     (rd_q)
);

// File: tb/mgmt_serial_master_tb.sv
module mgmt_serial_master_tb;

    localparam int HALF_DIV = 2;
    localparam logic [4:0] PHY_ID = 5'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy   = '0;
    logic [4:0]  req_regad = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, rd_err, mdc, mdio_o, mdio_oe, mdio_dir;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    mgmt_serial_master #(.HALF_DIV(HALF_DIV)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_regad(req_regad), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_dir(mdio_dir),
        .mdio_i(mdio_i)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] patt(input int i);
        patt = 16'((i * 16'h3A71) ^ 16'hC35A ^ (i << 11));
    endfunction

    // PHY model and link monitor
    logic [15:0] phy_regs [32];
    logic [63:0] cap = '0;
    logic [63:0] cap_oe = '0;
    int  edge_n = 0;
    int  cyc = 0, t_first = 0, t_second = 0;
    int  done_seen = 0, oe_glitch = 0;
    logic prev_mdc = 1'b0, prev_oe = 1'b1;
    bit  phy_bad_ta = 0;
    bit  hit_rd = 0;
    logic [4:0] hit_reg = '0;

    always @(negedge clk) begin
        cyc++;
        if (done) done_seen++;
        if (!rst && (mdio_oe !== prev_oe) && (mdc || prev_mdc)) oe_glitch++;
        if (!busy) begin
            edge_n = 0;
        end else if (mdc && !prev_mdc) begin
            edge_n++;
            cap    = {cap[62:0], mdio_o};
            cap_oe = {cap_oe[62:0], mdio_oe};
            if (edge_n == 1) t_first = cyc;
            if (edge_n == 2) t_second = cyc;
            if (edge_n == 46) begin
                hit_rd  = (cap[11:10] == 2'b10) && (cap[9:5] == PHY_ID);
                hit_reg = cap[4:0];
            end
            if (edge_n == 47 && hit_rd) mdio_i = phy_bad_ta;
            if (edge_n >= 48 && edge_n <= 63 && hit_rd) mdio_i = phy_regs[hit_reg][63 - edge_n];
            if (edge_n == 64) begin
                mdio_i = 1'b1;
                hit_rd = 0;
                if (cap[29:28] == 2'b01 && cap[27:23] == PHY_ID) phy_regs[cap[22:18]] = cap[15:0];
            end
        end
        prev_mdc = mdc;
        prev_oe  = mdio_oe;
    end

    logic [15:0] r_data;
    logic        r_err;
    int          r_edges;

    task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_regad = ra; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        r_data = rd_data; r_err = rd_err; r_edges = edge_n;
        @(negedge clk);
        check(!done && !busy, "R10 done single pulse", {62'd0, done, busy}, 64'd0);
    endtask

    task automatic check_frame(input bit wr, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
        logic [63:0] exp;
        exp = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, wd};
        check(cap[63:32] == 32'hFFFF_FFFF && cap_oe[63:32] == 32'hFFFF_FFFF,
              "R4 preamble", cap[63:32], 64'hFFFF_FFFF);
        check(cap[31:18] == exp[31:18], "R5 header fields", 64'(cap[31:18]), 64'(exp[31:18]));
        if (wr) begin
            check(cap[17:0] == exp[17:0], "R6 write turnaround and data", 64'(cap[17:0]), 64'(exp[17:0]));
            check(cap_oe == '1 && r_edges == 64, "R6 write drive and length", cap_oe, 64'(r_edges));
        end else begin
            check(cap_oe == {{46{1'b1}}, 18'd0}, "R7 read release window", cap_oe, {{46{1'b1}}, 18'd0});
            check(r_edges == 64, "R8 read frame length", 64'(r_edges), 64'd64);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) phy_regs[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mdc && mdio_oe && mdio_dir && mdio_o, "R1 reset state",
              {58'd0, busy, done, mdc, mdio_oe, mdio_dir, mdio_o}, 64'h7);

        for (int r = 0; r < 32; r++) begin
            run_txn(1'b1, PHY_ID, 5'(r), patt(r));
            check_frame(1'b1, PHY_ID, 5'(r), patt(r));
            check(r_err == 1'b0 && r_data == 16'd0, "R10 write result zero", {47'd0, r_err, r_data}, 64'd0);
            if (r == 0)
                check(t_second - t_first == 2 * HALF_DIV, "R3 clock period",
                      64'(t_second - t_first), 64'(2 * HALF_DIV));
        end

        for (int r = 0; r < 32; r++) begin
            run_txn(1'b0, PHY_ID, 5'(r), 16'hFFFF);
            check_frame(1'b0, PHY_ID, 5'(r), 16'h0);
            check(r_err == 1'b0 && r_data == patt(r), "R8 read data", {47'd0, r_err, r_data}, 64'(patt(r)));
        end

        run_txn(1'b0, 5'd17, 5'd4, 16'h0);
        check_frame(1'b0, 5'd17, 5'd4, 16'h0);
        check(r_err == 1'b1 && r_data == 16'd0, "R9 absent PHY", {47'd0, r_err, r_data}, 64'h1_0000);

        phy_bad_ta = 1;
        run_txn(1'b0, PHY_ID, 5'd7, 16'h0);
        check(r_err == 1'b1 && r_data == 16'd0, "R9 high turnaround forces zero", {47'd0, r_err, r_data}, 64'h1_0000);
        phy_bad_ta = 0;

        // R2: request presented mid-frame must be ignored
        begin
            int seen0;
            seen0 = done_seen;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_phy = PHY_ID; req_regad = 5'd5; req_wdata = 16'h5A5A;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (20) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_phy = PHY_ID; req_regad = 5'd9;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (800) @(negedge clk);
            check(done_seen - seen0 == 1 && !busy, "R2 busy request ignored", 64'(done_seen - seen0), 64'd1);
            check(cap[29:18] == {2'b01, PHY_ID, 5'd5}, "R2 frame in flight intact", 64'(cap[29:18]), 64'({2'b01, PHY_ID, 5'd5}));
        end
        run_txn(1'b0, PHY_ID, 5'd5, 16'h0);
        check(r_err == 1'b0 && r_data == 16'h5A5A, "R2 write survived", 64'(r_data), 64'h5A5A);

        check(oe_glitch == 0, "R7 enable changes only with clock low", 64'(oe_glitch), 64'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule